// File: doc/BRIEF.md
# MDIO Management Frame Slave

This block is the device side of a two-wire serial management bus. A station drives a slow management clock and a shared bidirectional data line. The block oversamples both wires with the local system clock and tracks each frame bit by bit. It recognises the run of ones that opens a frame, the start delimiter, the opcode and the two 5-bit address fields. It then either captures 16 bits of write data or returns 16 bits of read data after a turnaround slot.

Several devices can share the bus. Each device answers only to its own PHY address, and the rest of a frame addressed to another device is skipped. A small register bank holds two registers. The first is a status word, which contains a bit that lets frames start without the opening ones. The second is a control word, which holds an override bit and the device's own address. The address field is loaded from strap pins at reset. The suppression bit is write-protected: it changes only while the override bit is already set.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: While suppression is off, a frame is recognised only after at least 32 consecutive ones sampled on management clock rising edges. A frame opened by 31 or fewer ones gets no response.
- R2: A zero sampled while hunting for the opening ones restarts the count, so the ones on either side of that zero do not add up.
- R3: The two bits after the opening ones must be 0 then 1. Any other pair abandons the frame, and no register changes.
- R4: Opcode 10 is a read. In the first turnaround bit the line is left undriven. In the second turnaround bit the block drives 0. It then drives the 16 data bits MSB first, each launched after a management clock falling edge. The output enable is released at the falling edge that follows the 16th data bit, so the block drives for exactly 17 bit slots.
- R5: Opcode 01 is a write. The station sends turnaround bits 1 then 0, followed by 16 data bits MSB first, which are sampled on rising edges and committed after the last one. The block never drives the line during a write.
- R6: Opcodes 00 and 11 cause no drive and no register change. The rest of that frame (28 bits) is skipped.
- R7: After the opcode come a 5-bit PHY address and a 5-bit register address, both MSB first. The block responds only when the PHY address equals its own. On a mismatch it does not drive, changes no register, and skips the rest of the frame.
- R8: Register 16 reads back with the override in bit 15 and the device address in bits 10:6. All other bits read 0. Writing register 16 sets both fields. At reset, the address field takes the value of the strap input.
- R9: Register 1 reads as 0x7809, with bit 6 replaced by the suppression enable. The enable resets to 0. A write to bit 6 of register 1 takes effect only if the override bit was already 1 before that write frame.
- R10: While suppression is on, a frame that starts directly with the 0,1 delimiter from idle is accepted, with no opening ones needed.
- R11: Any register address other than 1 and 16 reads as 0x0000, and writes to such an address change nothing.
- R12: After reset, the output enable and the data output are 0, suppression is off, the override is clear, and the address field equals the strap input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc_i | input | 1 | Management clock from the station |
| mdio_i | input | 1 | Data line as seen at the pad input |
| strap_phy_i | input | 5 | Device address loaded into register 16 at reset |
| mdio_o | output | 1 | Data value to drive onto the line |
| mdio_oe | output | 1 | Output enable for the data line driver |

## Verification
Frames are tried with a full run of opening ones, a run one short of full, a run split by a zero, and, with suppression on, no run at all. Together these separate a correct preamble counter from one that saturates early, ignores zeros, or ignores the suppression bit. Reads and writes go to the status register, the control register and an unimplemented address, in an order that shows whether the protection rule depends on the previously written override. Broken delimiters, both invalid opcodes and a foreign PHY address are each followed by a readback, so a stray register update shows up at the ports. The exact count of driven bit slots in each read exposes an early or late release of the output enable.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 5;
  localparam int TA_BITS   = 2;
  localparam int SEQ_W     = 5;
  localparam int SKIP_ALL  = 2 * ADDR_W + TA_BITS + DATA_W;
  localparam int SKIP_TAIL = TA_BITS + DATA_W;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_SFD,
    ST_OP,
    ST_ADDR,
    ST_TA,
    ST_DATA,
    ST_SKIP
  } mf_state_e;

  function automatic logic op_is_valid(logic [1:0] op);
    return (op == OP_RD) || (op == OP_WR);
  endfunction

  // bit k of a word counted from the MSB
  function automatic logic msb_pick(logic [DATA_W-1:0] w, logic [SEQ_W-1:0] k);
    logic [DATA_W-1:0] t;
    t = w << k;
    return t[DATA_W-1];
  endfunction

  function automatic logic [DATA_W-1:0] stat_word(logic [DATA_W-1:0] fixed,
                                                  logic psup, int pos);
    logic [DATA_W-1:0] w;
    w = fixed;
    w[pos] = psup;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_word(logic ovr, logic [ADDR_W-1:0] phy,
                                                  int ovr_pos, int phy_lsb);
    logic [DATA_W-1:0] w;
    w = '0;
    w[ovr_pos] = ovr;
    w[phy_lsb +: ADDR_W] = phy;
    return w;
  endfunction

endpackage

// File: rtl/mdio_pin_sync.sv
module mdio_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc_i,
  input  logic mdio_i,
  output logic mdc_rise,
  output logic mdc_fall,
  output logic din
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] mdc_pipe;
  logic [STAGES-1:0] dio_pipe;
  logic              mdc_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_pipe <= '0;
      dio_pipe <= '1;
      mdc_last <= 1'b0;
    end else begin
      mdc_pipe[0] <= mdc_i;
      dio_pipe[0] <= mdio_i;
      for (int i = 1; i < STAGES; i++) begin
        mdc_pipe[i] <= mdc_pipe[i-1];
        dio_pipe[i] <= dio_pipe[i-1];
      end
      mdc_last <= mdc_pipe[LAST];
    end
  end

  assign mdc_rise = mdc_pipe[LAST] & ~mdc_last;
  assign mdc_fall = ~mdc_pipe[LAST] & mdc_last;
  assign din      = dio_pipe[LAST];

endmodule

// File: rtl/mdio_regbank.sv
module mdio_regbank
  import mdio_mgmt_pkg::*;
#(
  parameter int              REG_STAT   = 1,
  parameter int              REG_CTRL   = 16,
  parameter logic [DATA_W-1:0] STAT_FIXED = 16'h7809,
  parameter int              PSUP_BIT   = 6,
  parameter int              OVR_BIT    = 15,
  parameter int              PHY_LSB    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] strap_phy,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] my_phy,
  output logic              psup,
  output logic              ovr
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psup   <= 1'b0;
      ovr    <= 1'b0;
      my_phy <= strap_phy;
    end else if (wr_en) begin
      if (reg_addr == A_CTRL) begin
        ovr    <= wr_data[OVR_BIT];
        my_phy <= wr_data[PHY_LSB +: ADDR_W];
      end else if (reg_addr == A_STAT && ovr) begin
        psup <= wr_data[PSUP_BIT];
      end
    end
  end

  always_comb begin
    if (reg_addr == A_STAT)      rd_data = stat_word(STAT_FIXED, psup, PSUP_BIT);
    else if (reg_addr == A_CTRL) rd_data = ctrl_word(ovr, my_phy, OVR_BIT, PHY_LSB);
    else                         rd_data = '0;
  end

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              fall,
  input  logic              din,
  input  logic              psup,
  input  logic [ADDR_W-1:0] my_phy,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              mdio_o,
  output logic              mdio_oe,
  output mf_state_e         state,
  output logic              pre_full,
  output logic              frame_read,
  output logic              frame_write
);
  localparam int PC_W = $clog2(PRE_LEN + 1);
  localparam logic [PC_W-1:0]  PRE_MAX   = PC_W'(PRE_LEN);
  localparam logic [SEQ_W-1:0] ADDR_LAST = SEQ_W'(2 * ADDR_W - 1);
  localparam logic [SEQ_W-1:0] DATA_LAST = SEQ_W'(DATA_W - 1);

  logic [PC_W-1:0]     pre_cnt;
  logic [SEQ_W-1:0]    cnt;
  logic [1:0]          op_q;
  logic [2*ADDR_W-1:0] addr_sr;
  logic [2*ADDR_W-1:0] addr_nxt;
  logic [DATA_W-1:0]   wr_sr;
  logic [DATA_W-1:0]   rd_buf;

  assign pre_full    = (pre_cnt == PRE_MAX);
  assign frame_read  = (op_q == OP_RD);
  assign frame_write = (op_q == OP_WR);
  assign reg_addr    = addr_sr[ADDR_W-1:0];
  assign wr_data     = wr_sr;
  assign addr_nxt    = {addr_sr[2*ADDR_W-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_HUNT;
      pre_cnt <= '0;
      cnt     <= '0;
      op_q    <= '0;
      addr_sr <= '0;
      wr_sr   <= '0;
      rd_buf  <= '0;
      wr_en   <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (rise) begin
        case (state)
          ST_HUNT: begin
            if (din) begin
              if (!pre_full) pre_cnt <= pre_cnt + 1'b1;
            end else begin
              pre_cnt <= '0;
              if (pre_full || psup) state <= ST_SFD;
            end
          end
          ST_SFD: begin
            pre_cnt <= '0;
            cnt     <= '0;
            state   <= din ? ST_OP : ST_HUNT;
          end
          ST_OP: begin
            op_q <= {op_q[0], din};
            if (cnt == '0) begin
              cnt <= 1;
            end else if (op_is_valid({op_q[0], din})) begin
              cnt   <= '0;
              state <= ST_ADDR;
            end else begin
              cnt   <= SEQ_W'(SKIP_ALL);
              state <= ST_SKIP;
            end
          end
          ST_ADDR: begin
            addr_sr <= addr_nxt;
            if (cnt != ADDR_LAST) begin
              cnt <= cnt + 1'b1;
            end else if (addr_nxt[2*ADDR_W-1:ADDR_W] == my_phy) begin
              cnt   <= '0;
              state <= ST_TA;
            end else begin
              cnt   <= SEQ_W'(SKIP_TAIL);
              state <= ST_SKIP;
            end
          end
          ST_TA: begin
            if (cnt == '0) begin
              rd_buf <= rd_data;
              cnt    <= 1;
            end else begin
              cnt   <= '0;
              state <= ST_DATA;
            end
          end
          ST_DATA: begin
            wr_sr <= {wr_sr[DATA_W-2:0], din};
            if (cnt == DATA_LAST) begin
              wr_en   <= frame_write;
              pre_cnt <= '0;
              state   <= ST_HUNT;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_SKIP: begin
            if (cnt <= 1) begin
              pre_cnt <= '0;
              state   <= ST_HUNT;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          default: state <= ST_HUNT;
        endcase
      end
      if (fall) begin
        if (state == ST_TA && cnt == 1 && frame_read) begin
          mdio_oe <= 1'b1;
          mdio_o  <= 1'b0;
        end else if (state == ST_DATA && frame_read) begin
          mdio_oe <= 1'b1;
          mdio_o  <= msb_pick(rd_buf, cnt);
        end else begin
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_mgmt_pkg::*;
#(
  parameter int                PRE_LEN     = 32,
  parameter int                SYNC_STAGES = 2,
  parameter int                REG_STAT    = 1,
  parameter int                REG_CTRL    = 16,
  parameter logic [DATA_W-1:0] STAT_FIXED  = 16'h7809,
  parameter int                PSUP_BIT    = 6,
  parameter int                OVR_BIT     = 15,
  parameter int                PHY_LSB     = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mdc_i,
  input  logic       mdio_i,
  input  logic [4:0] strap_phy_i,
  output logic       mdio_o,
  output logic       mdio_oe
);
  logic              mdc_rise, mdc_fall, din;
  logic              psup, ovr, wr_en;
  logic              pre_full, frame_read, frame_write;
  logic [ADDR_W-1:0] my_phy, reg_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  mf_state_e         fsm_state;

  mdio_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .mdc_i(mdc_i), .mdio_i(mdio_i),
    .mdc_rise(mdc_rise), .mdc_fall(mdc_fall), .din(din)
  );

  mdio_frame_fsm #(.PRE_LEN(PRE_LEN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rise(mdc_rise), .fall(mdc_fall), .din(din),
    .psup(psup), .my_phy(my_phy), .rd_data(rd_data),
    .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .state(fsm_state),
    .pre_full(pre_full), .frame_read(frame_read), .frame_write(frame_write)
  );

  mdio_regbank #(
    .REG_STAT(REG_STAT), .REG_CTRL(REG_CTRL), .STAT_FIXED(STAT_FIXED),
    .PSUP_BIT(PSUP_BIT), .OVR_BIT(OVR_BIT), .PHY_LSB(PHY_LSB)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .strap_phy(strap_phy_i),
    .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data),
    .rd_data(rd_data), .my_phy(my_phy), .psup(psup), .ovr(ovr)
  );

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker
  import mdio_mgmt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              oe,
  input logic              dout,
  input mf_state_e         state,
  input logic              pre_full,
  input logic              psup,
  input logic              ovr,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] phy,
  input logic              frame_read,
  input logic              frame_write
);
  assert_sfd_after_preamble_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SFD && $past(state) == ST_HUNT && !$past(psup)) |-> $past(pre_full));

  assert_ta_drives_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> (!dout && state == ST_TA));

  assert_drive_only_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> frame_read);

  assert_commit_only_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> frame_write);

  assert_psup_needs_override_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(psup) |-> $past(ovr));

  assert_unmapped_write_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != 5'd1 && wr_addr != 5'd16) |=> $stable({psup, ovr, phy}));

endmodule

bind mdio_mgmt_slave mdio_mgmt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .oe(mdio_oe), .dout(mdio_o), .state(fsm_state),
  .pre_full(pre_full), .psup(psup), .ovr(ovr), .wr_en(wr_en),
  .wr_addr(reg_addr), .phy(my_phy), .frame_read(frame_read),
  .frame_write(frame_write)
);

// File: tb/sim_mdio_mgmt_slave.sv
`timescale 1ns/1ps
module sim_mdio_mgmt_slave;
  localparam int HALF = 8;
  localparam logic [4:0] STRAP = 5'd3;
  localparam int NVEC = 16;
  // {expect_response, is_write, phy, reg, data_or_expected}
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 5'd3, 5'd1,  16'h7809},
    {1'b1, 1'b0, 5'd3, 5'd16, 16'h00C0},
    {1'b0, 1'b1, 5'd3, 5'd1,  16'hFFFF},
    {1'b1, 1'b0, 5'd3, 5'd1,  16'h7809},
    {1'b0, 1'b1, 5'd3, 5'd16, 16'h80C0},
    {1'b1, 1'b0, 5'd3, 5'd16, 16'h80C0},
    {1'b0, 1'b1, 5'd3, 5'd1,  16'h0040},
    {1'b1, 1'b0, 5'd3, 5'd1,  16'h7849},
    {1'b0, 1'b1, 5'd3, 5'd5,  16'hABCD},
    {1'b1, 1'b0, 5'd3, 5'd5,  16'h0000},
    {1'b1, 1'b0, 5'd3, 5'd16, 16'h80C0},
    {1'b0, 1'b1, 5'd3, 5'd16, 16'h8140},
    {1'b1, 1'b0, 5'd5, 5'd16, 16'h8140},
    {1'b0, 1'b0, 5'd3, 5'd16, 16'h0000},
    {1'b0, 1'b1, 5'd5, 5'd16, 16'h80C0},
    {1'b1, 1'b0, 5'd3, 5'd1,  16'h7849}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mdc_i = 1'b0;
  logic mdio_i = 1'b1;
  logic mdio_o, mdio_oe;
  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  mdio_mgmt_slave u0 (
    .clk(clk), .rst_n(rst_n), .mdc_i(mdc_i), .mdio_i(mdio_i),
    .strap_phy_i(STRAP), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<%0d", cycles, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b, output logic s_oe, output logic s_o);
    mdio_i = b;
    repeat (HALF) @(posedge clk);
    @(negedge clk);
    s_oe = mdio_oe;
    s_o  = mdio_o;
    mdc_i = 1'b1;
    repeat (HALF) @(posedge clk);
    @(negedge clk);
    mdc_i = 1'b0;
  endtask

  task automatic ones(input int n);
    logic a, b;
    for (int i = 0; i < n; i++) clk_bit(1'b1, a, b);
  endtask

  task automatic zero_bit();
    logic a, b;
    clk_bit(1'b0, a, b);
  endtask

  task automatic run_frame(input int npre, input logic [1:0] sfd, input logic [1:0] op,
                           input logic [4:0] phy, input logic [4:0] ra, input logic drv,
                           input logic [15:0] wd, output logic [15:0] rd,
                           output int ndrv, output logic ta_ok);
    logic soe, so, t1oe;
    ndrv = 0; rd = '0; ta_ok = 1'b0;
    for (int i = 0; i < npre; i++) begin clk_bit(1'b1, soe, so); ndrv += int'(soe); end
    for (int i = 1; i >= 0; i--) begin clk_bit(sfd[i], soe, so); ndrv += int'(soe); end
    for (int i = 1; i >= 0; i--) begin clk_bit(op[i], soe, so); ndrv += int'(soe); end
    for (int i = 4; i >= 0; i--) begin clk_bit(phy[i], soe, so); ndrv += int'(soe); end
    for (int i = 4; i >= 0; i--) begin clk_bit(ra[i], soe, so); ndrv += int'(soe); end
    clk_bit(1'b1, soe, so); t1oe = soe; ndrv += int'(soe);
    clk_bit(drv ? 1'b0 : 1'b1, soe, so); ndrv += int'(soe);
    ta_ok = !t1oe && soe && !so;
    for (int i = 15; i >= 0; i--) begin
      clk_bit(drv ? wd[i] : 1'b1, soe, so);
      rd[i] = so;
      ndrv += int'(soe);
    end
    clk_bit(1'b1, soe, so); ndrv += int'(soe);
  endtask

  task automatic rd_expect(input int npre, input logic [4:0] ra, input logic [15:0] exp, input string req);
    logic [15:0] rd; int nd; logic ta;
    run_frame(npre, 2'b01, 2'b10, 5'd3, ra, 1'b0, 16'h0, rd, nd, ta);
    chk(nd == 17, req, 32'(nd), 32'd17);
    chk(ta, req, {31'd0, ta}, 32'd1);
    chk(rd == exp, req, {16'd0, rd}, {16'd0, exp});
  endtask

  task automatic rd_silent(input int npre, input logic [4:0] phy, input string req);
    logic [15:0] rd; int nd; logic ta;
    run_frame(npre, 2'b01, 2'b10, phy, 5'd1, 1'b0, 16'h0, rd, nd, ta);
    chk(nd == 0, req, 32'(nd), 32'd0);
  endtask

  initial begin
    logic [15:0] rd; int nd; logic ta;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    chk(mdio_oe == 1'b0, "R12 oe after reset", {31'd0, mdio_oe}, 32'd0);
    chk(mdio_o == 1'b0, "R12 dout after reset", {31'd0, mdio_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      logic resp, wr; logic [4:0] phy, ra; logic [15:0] dat;
      {resp, wr, phy, ra, dat} = VEC[v];
      if (wr) begin
        run_frame(32, 2'b01, 2'b01, phy, ra, 1'b1, dat, rd, nd, ta);
        chk(nd == 0, "R5 write frame leaves bus released", 32'(nd), 32'd0);
      end else begin
        run_frame(32, 2'b01, 2'b10, phy, ra, 1'b0, 16'h0, rd, nd, ta);
        if (!resp) begin
          chk(nd == 0, "R7 foreign address read not driven", 32'(nd), 32'd0);
        end else begin
          chk(nd == 17, "R4 driven slot count", 32'(nd), 32'd17);
          chk(ta, "R4 turnaround Z then 0", {31'd0, ta}, 32'd1);
          if (ra == 5'd1)
            chk(rd == dat, "R9 status readback", {16'd0, rd}, {16'd0, dat});
          else if (ra == 5'd16)
            chk(rd == dat, "R8 control readback", {16'd0, rd}, {16'd0, dat});
          else
            chk(rd == dat, "R11 unmapped readback", {16'd0, rd}, {16'd0, dat});
        end
      end
    end

    // R10: suppression on, frame straight from idle
    rd_expect(0, 5'd1, 16'h7849, "R10 no-preamble frame accepted");

    // turn suppression off (override still set)
    run_frame(32, 2'b01, 2'b01, 5'd3, 5'd1, 1'b1, 16'h0000, rd, nd, ta);
    rd_silent(0, 5'd3, "R1 no preamble rejected");
    zero_bit();
    rd_silent(31, 5'd3, "R1 31 ones rejected");
    zero_bit();
    rd_expect(32, 5'd1, 16'h7809, "R1 32 ones accepted");

    // R2: zero splits the preamble
    zero_bit();
    ones(20);
    zero_bit();
    rd_silent(20, 5'd3, "R2 split preamble rejected");
    zero_bit();

    // R3: bad delimiter on a write to the control register
    run_frame(32, 2'b00, 2'b01, 5'd3, 5'd16, 1'b1, 16'h0000, rd, nd, ta);
    chk(nd == 0, "R3 bad delimiter not driven", 32'(nd), 32'd0);
    rd_expect(32, 5'd16, 16'h80C0, "R3 bad delimiter no write");

    // R6: invalid opcodes
    run_frame(32, 2'b01, 2'b11, 5'd3, 5'd1, 1'b0, 16'h0, rd, nd, ta);
    chk(nd == 0, "R6 opcode 11 not driven", 32'(nd), 32'd0);
    run_frame(32, 2'b01, 2'b00, 5'd3, 5'd16, 1'b1, 16'h0000, rd, nd, ta);
    chk(nd == 0, "R6 opcode 00 not driven", 32'(nd), 32'd0);
    rd_expect(32, 5'd16, 16'h80C0, "R6 invalid opcode no write");

    // R7: write to a foreign address
    run_frame(32, 2'b01, 2'b01, 5'd7, 5'd16, 1'b1, 16'h0000, rd, nd, ta);
    rd_expect(32, 5'd16, 16'h80C0, "R7 foreign write ignored");

    // R12 / R8: reset returns strap address and clears bits
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mdio_oe == 1'b0, "R12 oe in reset", {31'd0, mdio_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd_expect(32, 5'd16, 16'h00C0, "R8 strap address after reset");
    rd_expect(32, 5'd1, 16'h7809, "R12 suppression cleared by reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule